// File: doc/BRIEF.md
# Hierarchical Vertical-and-Crosswise Multiplier

This block is a purely combinational unsigned multiplier. It takes two 16-bit operands and drives their full 32-bit product with no truncation. It is meant to sit in a datapath where a product is needed in the same cycle as its operands, for example ahead of a register stage in a filter or transform pipeline.

The product is built by recursive halving. Each operand is split into a high half and a low half, and the four half-width products are formed by smaller copies of the same structure, down to a gate-level 2x2 cell. Each level merges its four sub-products in three steps. The low-by-low product supplies the bottom bits directly. Its upper half is added to one crosswise product, and the other crosswise product is added to that sum. Last, the high-by-high product is added at the top, which also absorbs the carries from the crosswise step. Every adder is a ripple chain of a full-adder cell that uses two XOR gates and one 2:1 multiplexer.

Top module: `vedic_mul16`

## Requirements
- R1: The 2x2 leaf cell returns {c2, s2, s1, s0} equal to the unsigned product of its two 2-bit inputs for all 16 input pairs. Here s0 is a0&b0, s1 is the XOR of the two cross terms, c1 is the AND of the cross terms, s2 is c1 XOR a1&b1, and c2 is c1 AND a1&b1.
- R2: The full-adder cell gives {carry, sum} equal to a+b+cin for all 8 input combinations. Its carry is cin when a differs from b, and a otherwise.
- R3: A ripple adder of W full-adder cells gives {cout, sum} equal to a+b+cin for every input.
- R4: Every intermediate unit (4x4, 8x8) outputs the exact unsigned product of its operands.
- R5: At each level, no adder in the merge produces a carry out of its top bit, including when both operands are all ones.
- R6: The top-level 32-bit output equals op_a*op_b for every operand pair. In particular, 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R7: A zero operand gives a zero product. An operand of 1 returns the other operand unchanged.
- R8: Single-bit operands 2^i and 2^j give exactly 2^(i+j) for all i, j in 0..15.
- R9: The product holds no state. It reflects new operands without any clock edge between the change and the observation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Unsigned multiplicand |
| op_b | input | 16 | Unsigned multiplier |
| prod | output | 32 | Full unsigned product op_a*op_b |

## Verification
Two functions meet in one evaluation: the carry out of the crosswise addition, and the addition of the high-by-high product that has to absorb it. Both peak on the same operands. All-ones operands at every level, and random vectors with long runs of ones, drive the crosswise sum and the top addition to their widest carries together. The result is judged against an arithmetic product computed in the bench. In-design checks also confirm that none of the three merge adders overflows when this happens.

// File: rtl/vm_pkg.sv
package vm_pkg;
   localparam int LEAF_W = 2;

   function automatic bit vm_is_pow2(input int n);
      return (n >= LEAF_W) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/vm_fa_mux.sv
module vm_fa_mux (
   input  logic a,
   input  logic b,
   input  logic cin,
   output logic sum,
   output logic cout
);
   logic prop;

   assign prop = a ^ b;
   assign sum  = prop ^ cin;
   assign cout = prop ? cin : a;

   always_comb begin
      AST_FA_ADD: assert ({cout, sum} == (2'(a) + 2'(b) + 2'(cin))); // R2
   end
endmodule

// File: rtl/vm_rca.sv
module vm_rca #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] s,
   output logic         cout
);
   localparam int SW = W + 1;

   logic [W:0] chain;

   generate
      if (W < 1) begin : g_bad_w
         $error("vm_rca: W must be at least 1");
      end
   endgenerate

   assign chain[0] = cin;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         vm_fa_mux u_fa (
            .a   (a[i]),
            .b   (b[i]),
            .cin (chain[i]),
            .sum (s[i]),
            .cout(chain[i+1])
         );
      end
   endgenerate

   assign cout = chain[W];

   always_comb begin
      AST_RCA_ADD: assert ({cout, s} == (SW'(a) + SW'(b) + SW'(cin))); // R3
   end
endmodule

// File: rtl/vm_leaf2.sv
module vm_leaf2 (
   input  logic [1:0] a,
   input  logic [1:0] b,
   output logic [3:0] p
);
   logic t_ll, t_hl, t_lh, t_hh;
   logic c_mid, s_mid, s_top, c_top;

   assign t_ll = a[0] & b[0];
   assign t_hl = a[1] & b[0];
   assign t_lh = a[0] & b[1];
   assign t_hh = a[1] & b[1];

   // first half adder: the two cross terms
   assign s_mid = t_hl ^ t_lh;
   assign c_mid = t_hl & t_lh;

   // second half adder: cross carry into the high term
   assign s_top = c_mid ^ t_hh;
   assign c_top = c_mid & t_hh;

   assign p = {c_top, s_top, s_mid, t_ll};

   always_comb begin
      AST_LEAF_PROD: assert (p == (4'(a) * 4'(b))); // R1
   end
endmodule

// File: rtl/vm_node.sv
module vm_node
   import vm_pkg::*;
#(
   parameter int N = 16
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [2*N-1:0] p
);
   localparam int PW = 2 * N;

   generate
      if (!vm_is_pow2(N)) begin : g_bad_n
         $error("vm_node: N must be a power of two, at least 2");
      end

      if (N == LEAF_W) begin : g_leaf
         vm_leaf2 u_leaf (
            .a(a),
            .b(b),
            .p(p)
         );
      end else begin : g_split
         localparam int H  = N / 2;
         localparam int MW = 3 * H;

         logic [N-1:0]  q_ll, q_lh, q_hl, q_hh;
         logic [N-1:0]  cross_lo;
         logic [MW-1:0] cross_all, upper;
         logic          ov_x, ov_m, ov_t;

         vm_node #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(q_ll));
         vm_node #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(q_lh));
         vm_node #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(q_hl));
         vm_node #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(q_hh));

         // step 2a: one cross product plus the spill of the low product
         vm_rca #(.W(N)) u_add_x (
            .a   (q_lh),
            .b   ({{H{1'b0}}, q_ll[N-1:H]}),
            .cin (1'b0),
            .s   (cross_lo),
            .cout(ov_x)
         );

         // step 2b: the second cross product
         vm_rca #(.W(MW)) u_add_m (
            .a   ({{H{1'b0}}, cross_lo}),
            .b   ({{H{1'b0}}, q_hl}),
            .cin (1'b0),
            .s   (cross_all),
            .cout(ov_m)
         );

         // step 3: the high product takes the crosswise carries
         vm_rca #(.W(MW)) u_add_t (
            .a   (cross_all),
            .b   ({q_hh, {H{1'b0}}}),
            .cin (1'b0),
            .s   (upper),
            .cout(ov_t)
         );

         assign p = {upper, q_ll[H-1:0]};

         always_comb begin
            AST_NO_OVERFLOW: assert (!(ov_x || ov_m || ov_t)); // R5
            AST_NODE_PROD: assert (p == (PW'(a) * PW'(b))); // R4
         end
      end
   endgenerate
endmodule

// File: rtl/vedic_mul16.sv
module vedic_mul16
   import vm_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0]   op_a,
   input  logic [WIDTH-1:0]   op_b,
   output logic [2*WIDTH-1:0] prod
);
   localparam int PW = 2 * WIDTH;

   generate
      if (!vm_is_pow2(WIDTH)) begin : g_bad_width
         $error("vedic_mul16: WIDTH must be a power of two, at least 2");
      end
   endgenerate

   vm_node #(.N(WIDTH)) u_root (
      .a(op_a),
      .b(op_b),
      .p(prod)
   );

   always_comb begin
      AST_FULL_PROD: assert (prod == (PW'(op_a) * PW'(op_b))); // R6
   end
endmodule

// File: tb/sim_vedic_mul16.sv
module sim_vedic_mul16;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [15:0] op_a, op_b;
   logic [31:0] prod;
   vedic_mul16 u0 (.op_a(op_a), .op_b(op_b), .prod(prod));

   logic fa_a, fa_b, fa_c, fa_s, fa_co;
   vm_fa_mux u_fa (.a(fa_a), .b(fa_b), .cin(fa_c), .sum(fa_s), .cout(fa_co));

   logic [3:0] r_a, r_b, r_s;
   logic       r_c, r_co;
   vm_rca #(.W(4)) u_rca (.a(r_a), .b(r_b), .cin(r_c), .s(r_s), .cout(r_co));

   logic [1:0] n2_a, n2_b;
   logic [3:0] n2_p;
   vm_node #(.N(2)) u_n2 (.a(n2_a), .b(n2_b), .p(n2_p));

   logic [3:0] n4_a, n4_b;
   logic [7:0] n4_p;
   vm_node #(.N(4)) u_n4 (.a(n4_a), .b(n4_b), .p(n4_p));

   logic [7:0]  n8_a, n8_b;
   logic [15:0] n8_p;
   vm_node #(.N(8)) u_n8 (.a(n8_a), .b(n8_b), .p(n8_p));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic top_case(input string req, input logic [15:0] a, input logic [15:0] b);
      @(posedge clk);
      op_a = a;
      op_b = b;
      @(negedge clk);
      chk(req, 64'(prod), 64'(a) * 64'(b));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL R6 watchdog act=hung exp=finished");
         finish_up();
      end
   end

   initial begin
      logic [31:0] x;
      x = 32'h1234_5678;
      op_a = '0; op_b = '0;
      fa_a = 0; fa_b = 0; fa_c = 0;
      r_a = '0; r_b = '0; r_c = 0;
      n2_a = '0; n2_b = '0; n4_a = '0; n4_b = '0; n8_a = '0; n8_b = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7 reset-time zero product", 64'(prod), 64'h0);
      rst_n = 1'b1;

      // sub-unit sweeps run in parallel with random top-level vectors
      for (int i = 0; i < 65536; i++) begin
         @(posedge clk);
         n8_a = i[15:8]; n8_b = i[7:0];
         n4_a = i[7:4];  n4_b = i[3:0];
         n2_a = i[3:2];  n2_b = i[1:0];
         fa_a = i[2]; fa_b = i[1]; fa_c = i[0];
         r_a = i[3:0]; r_b = i[7:4]; r_c = i[8];
         x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
         op_a = x[31:16]; op_b = x[15:0];
         @(negedge clk);
         chk("R4 8x8 unit", 64'(n8_p), 64'(i[15:8]) * 64'(i[7:0]));
         if (i < 256) chk("R4 4x4 unit", 64'(n4_p), 64'(i[7:4]) * 64'(i[3:0]));
         if (i < 16)  chk("R1 2x2 leaf", 64'(n2_p), 64'(i[3:2]) * 64'(i[1:0]));
         if (i < 8)   chk("R2 full adder", 64'({fa_co, fa_s}),
                          64'(i[2]) + 64'(i[1]) + 64'(i[0]));
         if (i < 512) chk("R3 ripple adder", 64'({r_co, r_s}),
                          64'(i[3:0]) + 64'(i[7:4]) + 64'(i[8]));
         chk("R6 random operands", 64'(prod), 64'(x[31:16]) * 64'(x[15:0]));
      end

      // widest carries: crosswise sum and top addition together (R5)
      top_case("R5 R6 all ones", 16'hFFFF, 16'hFFFF);
      chk("R6 all ones exact value", 64'(prod), 64'hFFFE0001);
      top_case("R5 all ones by 0x8001", 16'hFFFF, 16'h8001);
      top_case("R5 low half ones", 16'h00FF, 16'hFFFF);
      top_case("R7 zero left", 16'h0000, 16'hBEEF);
      top_case("R7 zero right", 16'hCAFE, 16'h0000);
      top_case("R7 one left", 16'h0001, 16'hA5C3);
      chk("R7 identity passes operand", 64'(prod), 64'hA5C3);
      top_case("R7 one right", 16'h7E81, 16'h0001);

      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            @(posedge clk);
            op_a = 16'(1) << i;
            op_b = 16'(1) << j;
            @(negedge clk);
            chk("R8 single-bit operands", 64'(prod), 64'(1) << (i + j));
         end
      end

      // R9: change operands and observe with no clock edge in between
      @(posedge clk);
      #0.5;
      op_a = 16'h1357; op_b = 16'h2468;
      #0.5;
      chk("R9 no clock needed", 64'(prod), 64'(16'h1357) * 64'(16'h2468));
      op_a = 16'hFFFF; op_b = 16'h0003;
      #0.5;
      chk("R9 second change same cycle", 64'(prod), 64'(16'hFFFF) * 64'(3));

      finish_up();
   end
endmodule